// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block sets the pace of an I2C master. From the peripheral clock it produces the SCL pull-down and marks two instants for the byte engine in front of it. The first is the cycle in which SDA may change after SCL falls. The second is the middle of the SCL high time, when SDA is sampled. The engine issues one command at a time: a data bit, a START or a STOP.

Three pairs of high and low counts are applied, one pair for each of standard, fast and high-speed operation. A two-bit speed field picks the pair. The counts are raised to fixed minimums before use. A programmable SDA hold delay places the data-change strobe inside the low phase. The delay is clamped so that data always settles before SCL is released.

The high-phase timer runs only while SCL is sensed high, so a slave holding SCL low stretches the clock, and this is flagged. For START and STOP the block drives SDA low itself through a condition output. It uses the selected high count as both the setup interval and the hold interval of each condition.

Top module: `i2c_scl_timing`

## Requirements
- R1: After reset, and whenever idle, `scl_low`, `sda_cond_low`, `sda_strobe`, `sample_strobe` and `done` are 0 and `cmd_ready` is 1.
- R2: `speed_mode` selects the count pair: 2'd1 standard, 2'd2 fast, 2'd3 high speed; 2'd0 is treated as standard.
- R3: A command begins with a low phase in which `scl_low` is 1 for exactly max(LO,8)+1 consecutive cycles, where LO is the selected low count.
- R4: In the high phase SCL is released (`scl_low` 0) for max(HI,6)+8 cycles in which `scl_in` is sensed high, where HI is the selected high count.
- R5: A programmed low count below 8 acts as 8 and a high count below 6 acts as 6.
- R6: `sda_strobe` is 1 for exactly one cycle per command, at low-phase cycle index H = min(HOLD+2, Leff-2). The first cycle with `scl_low` 1 is index 0, HOLD is `sda_hold_cnt` and Leff is the low length of R3.
- R7: When HOLD+2 exceeds Leff-2 the strobe is placed at Leff-2, at least one cycle before SCL is released.
- R8: High-phase cycles with `scl_in` low are not counted, and `scl_stretch` is 1 in exactly those cycles.
- R9: For a bit command (`cmd_kind` 2'd0 or 2'd3), `sample_strobe` is 1 for one cycle, at counted high cycle floor(Heff/2) (first counted cycle 0), where Heff is the high length of R4. START and STOP give no sample strobe.
- R10: START (`cmd_kind` 2'd1) clears `sda_cond_low` at the end of the strobe cycle. After the low phase, SCL stays released for 2*Heff counted cycles, and `sda_cond_low` rises after the first Heff. It stays 1 until the end of the strobe cycle of the next bit command.
- R11: STOP (`cmd_kind` 2'd2) sets `sda_cond_low` at the end of the strobe cycle. After the low phase, SCL stays released for 2*Heff counted cycles, and `sda_cond_low` falls after the first Heff.
- R12: Speed, counts, hold and kind are captured when a command is accepted (`cmd_valid` while `cmd_ready`). Input changes and `cmd_valid` pulses while busy have no effect.
- R13: `done` is 1 for exactly one cycle, the first idle cycle after the last counted high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request from the byte engine |
| cmd_kind | input | 2 | 0/3 bit, 1 START, 2 STOP |
| cmd_ready | output | 1 | Idle, command can be accepted |
| speed_mode | input | 2 | Count pair select |
| std_hi | input | CNT_W | Standard high count |
| std_lo | input | CNT_W | Standard low count |
| fast_hi | input | CNT_W | Fast high count |
| fast_lo | input | CNT_W | Fast low count |
| hs_hi | input | CNT_W | High-speed high count |
| hs_lo | input | CNT_W | High-speed low count |
| sda_hold_cnt | input | HOLD_W | SDA hold delay count |
| scl_in | input | 1 | Sensed SCL level |
| scl_low | output | 1 | Pull SCL low |
| sda_strobe | output | 1 | Byte engine may change SDA now |
| sample_strobe | output | 1 | Sample SDA now |
| sda_cond_low | output | 1 | Block pulls SDA low for START/STOP |
| scl_stretch | output | 1 | Slave is holding SCL low during a high phase |
| done | output | 1 | Command finished |

## Verification
The bench builds the block with CNT_W = 8 and HOLD_W = 8. This keeps every phase a few dozen cycles long, so one run reaches each speed pair, both minimum clamps and the hold clamp. A hold value of 200 against a 13-cycle low phase forces the clamp, and the values on either side of the clamp boundary fall within an 8-bit field. The narrow fields also make register changes in mid-command, stretched high phases and START/STOP hand-over to a following bit cheap to observe cycle by cycle.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

   typedef enum logic [1:0] {
      K_BIT   = 2'd0,
      K_START = 2'd1,
      K_STOP  = 2'd2
   } kind_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOW   = 2'd1,
      PH_HIGH  = 2'd2,
      PH_HIGH2 = 2'd3
   } phase_e;

   // code 3 is handled as an ordinary bit
   function automatic kind_e decode_kind(input logic [1:0] code);
      case (code)
         2'd1:    decode_kind = K_START;
         2'd2:    decode_kind = K_STOP;
         default: decode_kind = K_BIT;
      endcase
   endfunction

   // speed field to pair index: 0 standard, 1 fast, 2 high speed
   function automatic logic [1:0] pair_index(input logic [1:0] spd);
      case (spd)
         2'd2:    pair_index = 2'd1;
         2'd3:    pair_index = 2'd2;
         default: pair_index = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/tgen_floor.sv
// Raises a raw count to a minimum, then adds the fixed phase offset.
module tgen_floor #(
   parameter int W    = 16,
   parameter int MINV = 8,
   parameter int ADD  = 1
) (
   input  logic [W-1:0] raw,
   output logic [W:0]   eff
);
   logic [W:0] base;

   always_comb begin
      if (raw < W'(MINV)) base = (W+1)'(MINV);
      else                base = {1'b0, raw};
      eff = base + (W+1)'(ADD);
   end
endmodule

// File: rtl/tgen_pair_sel.sv
// Effective high/low lengths for every speed pair, then the selected one.
module tgen_pair_sel
   import i2c_tgen_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int MIN_HCNT = 6,
   parameter int MIN_LCNT = 8,
   parameter int HIGH_ADD = 8,
   parameter int LOW_ADD  = 1,
   parameter int NPAIR    = 3
) (
   input  logic [1:0]                  speed,
   input  logic [NPAIR-1:0][CNT_W-1:0] hi_raw,
   input  logic [NPAIR-1:0][CNT_W-1:0] lo_raw,
   output logic [CNT_W:0]              h_eff,
   output logic [CNT_W:0]              l_eff
);
   logic [NPAIR-1:0][CNT_W:0] h_all;
   logic [NPAIR-1:0][CNT_W:0] l_all;
   logic [1:0]                idx;

   for (genvar g = 0; g < NPAIR; g++) begin : g_pair
      tgen_floor #(.W(CNT_W), .MINV(MIN_HCNT), .ADD(HIGH_ADD)) u_hi (
         .raw (hi_raw[g]),
         .eff (h_all[g])
      );
      tgen_floor #(.W(CNT_W), .MINV(MIN_LCNT), .ADD(LOW_ADD)) u_lo (
         .raw (lo_raw[g]),
         .eff (l_all[g])
      );
   end

   assign idx   = pair_index(speed);
   assign h_eff = h_all[idx];
   assign l_eff = l_all[idx];
endmodule

// File: rtl/tgen_hold_calc.sv
// SDA change index inside the low phase: hold + offset, clamped so data
// settles before SCL is released.
module tgen_hold_calc #(
   parameter int HOLD_W   = 16,
   parameter int EW       = 17,
   parameter int HOLD_ADD = 2,
   parameter int GAP      = 2,
   localparam int CW      = (HOLD_W + 1 > EW) ? HOLD_W + 1 : EW
) (
   input  logic [HOLD_W-1:0] hold,
   input  logic [EW-1:0]     l_eff,
   output logic [CW-1:0]     hold_idx
);
   logic [CW-1:0] want;
   logic [CW-1:0] limit;

   always_comb begin
      want  = CW'(hold) + CW'(HOLD_ADD);
      limit = CW'(l_eff) - CW'(GAP);
      hold_idx = (want < limit) ? want : limit;
   end
endmodule

// File: rtl/tgen_phase_fsm.sv
// Phase sequencer: low phase with SDA strobe, stretch-aware high phase,
// second high interval for START/STOP conditions.
module tgen_phase_fsm
   import i2c_tgen_pkg::*;
#(
   parameter int EW  = 17,
   parameter int HW  = 17,
   localparam int CTW = (EW > HW) ? EW : HW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_kind,
   input  logic [EW-1:0] h_eff,
   input  logic [EW-1:0] l_eff,
   input  logic [HW-1:0] hold_idx,
   input  logic          scl_in,
   output logic          cmd_ready,
   output logic          scl_low,
   output logic          sda_strobe,
   output logic          sample_strobe,
   output logic          sda_cond_low,
   output logic          scl_stretch,
   output logic          done
);
   phase_e         phase;
   kind_e          kind_q;
   logic [CTW-1:0] cnt;
   logic [CTW-1:0] h_q;
   logic [CTW-1:0] l_q;
   logic [CTW-1:0] hd_q;
   logic           last_hi;
   logic           last_lo;
   logic           in_high;

   assign last_hi = (cnt == h_q - CTW'(1));
   assign last_lo = (cnt == l_q - CTW'(1));
   assign in_high = (phase == PH_HIGH) || (phase == PH_HIGH2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= PH_IDLE;
         kind_q       <= K_BIT;
         cnt          <= '0;
         h_q          <= '0;
         l_q          <= '0;
         hd_q         <= '0;
         sda_cond_low <= 1'b0;
         done         <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (cmd_valid) begin
                  kind_q <= decode_kind(cmd_kind);
                  h_q    <= CTW'(h_eff);
                  l_q    <= CTW'(l_eff);
                  hd_q   <= CTW'(hold_idx);
                  cnt    <= '0;
                  phase  <= PH_LOW;
               end
            end
            PH_LOW: begin
               if (cnt == hd_q) sda_cond_low <= (kind_q == K_STOP);
               if (last_lo) begin
                  cnt   <= '0;
                  phase <= PH_HIGH;
               end else begin
                  cnt <= cnt + CTW'(1);
               end
            end
            PH_HIGH: begin
               if (scl_in) begin
                  if (last_hi) begin
                     cnt <= '0;
                     if (kind_q == K_BIT) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                     end else begin
                        phase        <= PH_HIGH2;
                        sda_cond_low <= (kind_q == K_START);
                     end
                  end else begin
                     cnt <= cnt + CTW'(1);
                  end
               end
            end
            default: begin
               if (scl_in) begin
                  if (last_hi) begin
                     cnt   <= '0;
                     phase <= PH_IDLE;
                     done  <= 1'b1;
                  end else begin
                     cnt <= cnt + CTW'(1);
                  end
               end
            end
         endcase
      end
   end

   assign cmd_ready     = (phase == PH_IDLE);
   assign scl_low       = (phase == PH_LOW);
   assign sda_strobe    = (phase == PH_LOW) && (cnt == hd_q);
   assign sample_strobe = (phase == PH_HIGH) && (kind_q == K_BIT) && scl_in
                          && (cnt == (h_q >> 1));
   assign scl_stretch   = in_high && !scl_in;
endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing
   import i2c_tgen_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int HOLD_W   = 16,
   parameter int MIN_HCNT = 6,
   parameter int MIN_LCNT = 8,
   parameter int HIGH_ADD = 8,
   parameter int LOW_ADD  = 1,
   parameter int HOLD_ADD = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_kind,
   output logic              cmd_ready,
   input  logic [1:0]        speed_mode,
   input  logic [CNT_W-1:0]  std_hi,
   input  logic [CNT_W-1:0]  std_lo,
   input  logic [CNT_W-1:0]  fast_hi,
   input  logic [CNT_W-1:0]  fast_lo,
   input  logic [CNT_W-1:0]  hs_hi,
   input  logic [CNT_W-1:0]  hs_lo,
   input  logic [HOLD_W-1:0] sda_hold_cnt,
   input  logic              scl_in,
   output logic              scl_low,
   output logic              sda_strobe,
   output logic              sample_strobe,
   output logic              sda_cond_low,
   output logic              scl_stretch,
   output logic              done
);
   localparam int EW    = CNT_W + 1;
   localparam int HW    = (HOLD_W + 1 > EW) ? HOLD_W + 1 : EW;
   localparam int NPAIR = 3;
   localparam int GAP   = 2;

   if (CNT_W < 4) begin : g_chk_cnt
      $error("CNT_W must be at least 4");
   end
   if (HOLD_W < 1) begin : g_chk_hold
      $error("HOLD_W must be at least 1");
   end
   if (MIN_LCNT + LOW_ADD < GAP + 2) begin : g_chk_low
      $error("minimum low phase too short for the hold clamp");
   end
   if (MIN_HCNT + HIGH_ADD < 2) begin : g_chk_high
      $error("minimum high phase too short for a midpoint");
   end

   logic [EW-1:0] h_eff;
   logic [EW-1:0] l_eff;
   logic [HW-1:0] hold_idx;

   tgen_pair_sel #(
      .CNT_W(CNT_W), .MIN_HCNT(MIN_HCNT), .MIN_LCNT(MIN_LCNT),
      .HIGH_ADD(HIGH_ADD), .LOW_ADD(LOW_ADD), .NPAIR(NPAIR)
   ) u_sel (
      .speed  (speed_mode),
      .hi_raw ({hs_hi, fast_hi, std_hi}),
      .lo_raw ({hs_lo, fast_lo, std_lo}),
      .h_eff  (h_eff),
      .l_eff  (l_eff)
   );

   tgen_hold_calc #(
      .HOLD_W(HOLD_W), .EW(EW), .HOLD_ADD(HOLD_ADD), .GAP(GAP)
   ) u_hold (
      .hold     (sda_hold_cnt),
      .l_eff    (l_eff),
      .hold_idx (hold_idx)
   );

   tgen_phase_fsm #(.EW(EW), .HW(HW)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_kind      (cmd_kind),
      .h_eff         (h_eff),
      .l_eff         (l_eff),
      .hold_idx      (hold_idx),
      .scl_in        (scl_in),
      .cmd_ready     (cmd_ready),
      .scl_low       (scl_low),
      .sda_strobe    (sda_strobe),
      .sample_strobe (sample_strobe),
      .sda_cond_low  (sda_cond_low),
      .scl_stretch   (scl_stretch),
      .done          (done)
   );
endmodule

// File: rtl/tgen_checker.sv
module tgen_checker #(
   parameter int MIN_LOW_CYC  = 9,
   parameter int MIN_HIGH_CYC = 14
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic cmd_ready,
   input logic scl_in,
   input logic scl_low,
   input logic sda_strobe,
   input logic sample_strobe,
   input logic scl_stretch,
   input logic done
);
   logic [31:0] low_run;
   logic [31:0] high_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         high_run <= '0;
      end else begin
         low_run  <= scl_low ? low_run + 32'd1 : '0;
         high_run <= scl_low ? '0 : high_run + 32'd1;
      end
   end

   // R3 / R5: a finished low phase is never shorter than the minimum
   p_low_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_low) |-> (low_run >= 32'(MIN_LOW_CYC)));

   // R4 / R5: a command ends only after at least the minimum high time
   p_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (high_run >= 32'(MIN_HIGH_CYC)));

   // R12: SCL is pulled low only right after an accepted command
   p_start_on_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_low) |-> $past(cmd_valid && cmd_ready));

   // R6: the data-change strobe falls inside the low phase
   p_strobe_in_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sda_strobe |-> scl_low);

   // R9: sampling only while SCL is released and sensed high
   p_sample_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_strobe |-> (!scl_low && scl_in));

   // R8: stretch flag only when the bus is held low by someone else
   p_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_stretch |-> (!scl_low && !scl_in && !cmd_ready));

   // R13: done lasts one cycle
   p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind i2c_scl_timing tgen_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .scl_in        (scl_in),
   .scl_low       (scl_low),
   .sda_strobe    (sda_strobe),
   .sample_strobe (sample_strobe),
   .scl_stretch   (scl_stretch),
   .done          (done)
);

// File: tb/tb_i2c_scl_timing.sv
module tb_i2c_scl_timing;
   localparam int CW = 8;
   localparam int HW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_kind = 2'd0;
   logic          cmd_ready;
   logic [1:0]    speed_mode = 2'd1;
   logic [CW-1:0] std_hi = 8'd10, std_lo = 8'd12;
   logic [CW-1:0] fast_hi = 8'd6, fast_lo = 8'd9;
   logic [CW-1:0] hs_hi = 8'd20, hs_lo = 8'd30;
   logic [HW-1:0] sda_hold_cnt = 8'd3;
   logic          ext_hold = 1'b0;
   logic          scl_in;
   logic          scl_low, sda_strobe, sample_strobe, sda_cond_low, scl_stretch, done;

   int checks = 0;
   int failures = 0;

   // measurement results
   int low_n, hi_n, strobe_at, samp_at, nstrobe, nsamp, str_n;
   int hl_low_first, hl_low_fall, hl_hi_rise, hl_hi_fall, fin;

   assign scl_in = !scl_low && !ext_hold;

   always #10 clk = !clk;

   i2c_scl_timing #(.CNT_W(CW), .HOLD_W(HW)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
      .cmd_ready(cmd_ready), .speed_mode(speed_mode),
      .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
      .hs_hi(hs_hi), .hs_lo(hs_lo), .sda_hold_cnt(sda_hold_cnt),
      .scl_in(scl_in), .scl_low(scl_low), .sda_strobe(sda_strobe),
      .sample_strobe(sample_strobe), .sda_cond_low(sda_cond_low),
      .scl_stretch(scl_stretch), .done(done)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [1:0] kind, input int stretch_n, input bit disturb);
      bit seen_low = 0;
      low_n = 0; hi_n = 0; strobe_at = -1; samp_at = -1; nstrobe = 0; nsamp = 0;
      str_n = 0; hl_low_first = -1; hl_low_fall = -1; hl_hi_rise = -1; hl_hi_fall = -1;
      fin = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_kind = kind;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         if (i > 0) @(negedge clk);
         if (seen_low && !scl_low) ext_hold = (hi_n < stretch_n);
         else ext_hold = 1'b0;
         if (disturb && i == 3) begin
            cmd_valid = 1'b1; cmd_kind = 2'd2;
            std_hi = 8'd50; std_lo = 8'd50; sda_hold_cnt = 8'd40; speed_mode = 2'd3;
         end
         if (disturb && i == 4) cmd_valid = 1'b0;
         #1;
         if (done) begin fin = 1; break; end
         if (scl_low) begin
            seen_low = 1;
            if (sda_strobe) begin nstrobe++; strobe_at = low_n; end
            if (sda_cond_low && hl_low_first < 0) hl_low_first = low_n;
            if (!sda_cond_low && hl_low_fall < 0) hl_low_fall = low_n;
            low_n++;
         end else if (seen_low) begin
            if (sample_strobe) begin nsamp++; samp_at = hi_n; end
            if (scl_stretch) str_n++;
            if (sda_cond_low && hl_hi_rise < 0) hl_hi_rise = hi_n;
            if (!sda_cond_low && hl_hi_fall < 0) hl_hi_fall = hi_n;
            hi_n++;
         end
      end
      ext_hold = 1'b0;
      chk("R13 command completes with done", fin, 1);
      @(negedge clk); #1;
      chk("R13 done is a single cycle", int'(done), 0);
   endtask

   task automatic t_reset();
      chk("R1 reset scl_low", int'(scl_low), 0);
      chk("R1 reset sda_cond_low", int'(sda_cond_low), 0);
      chk("R1 reset strobes", int'(sda_strobe | sample_strobe | done), 0);
      chk("R1 reset cmd_ready", int'(cmd_ready), 1);
   endtask

   task automatic t_standard();
      speed_mode = 2'd1; std_hi = 8'd10; std_lo = 8'd12; sda_hold_cnt = 8'd3;
      run_cmd(2'd0, 0, 0);
      chk("R3 standard low length", low_n, 13);
      chk("R4 standard high length", hi_n, 18);
      chk("R6 standard strobe index", strobe_at, 5);
      chk("R6 one strobe", nstrobe, 1);
      chk("R9 sample index", samp_at, 9);
      chk("R9 one sample", nsamp, 1);
      chk("R1 idle after bit cond low", int'(sda_cond_low), 0);
   endtask

   task automatic t_fast();
      speed_mode = 2'd2; fast_hi = 8'd7; fast_lo = 8'd9; sda_hold_cnt = 8'd0;
      run_cmd(2'd3, 0, 0);
      chk("R2 fast low length", low_n, 10);
      chk("R2 fast high length", hi_n, 15);
      chk("R6 fast strobe index", strobe_at, 2);
      chk("R9 sample index odd length, code 3", samp_at, 7);
   endtask

   task automatic t_high_speed();
      speed_mode = 2'd3; hs_hi = 8'd20; hs_lo = 8'd30; sda_hold_cnt = 8'd5;
      run_cmd(2'd0, 0, 0);
      chk("R2 hs low length", low_n, 31);
      chk("R2 hs high length", hi_n, 28);
      chk("R6 hs strobe index", strobe_at, 7);
      chk("R9 hs sample index", samp_at, 14);
   endtask

   task automatic t_speed_zero();
      speed_mode = 2'd0; std_hi = 8'd10; std_lo = 8'd12; sda_hold_cnt = 8'd3;
      run_cmd(2'd0, 0, 0);
      chk("R2 speed 0 low uses standard", low_n, 13);
      chk("R2 speed 0 high uses standard", hi_n, 18);
   endtask

   task automatic t_minimums();
      speed_mode = 2'd2; fast_hi = 8'd1; fast_lo = 8'd2; sda_hold_cnt = 8'd0;
      run_cmd(2'd0, 0, 0);
      chk("R5 low raised to minimum", low_n, 9);
      chk("R5 high raised to minimum", hi_n, 14);
      fast_hi = 8'd0; fast_lo = 8'd0;
      run_cmd(2'd0, 0, 0);
      chk("R5 zero low count", low_n, 9);
      chk("R5 zero high count", hi_n, 14);
   endtask

   task automatic t_hold_clamp();
      speed_mode = 2'd1; std_hi = 8'd10; std_lo = 8'd12;
      sda_hold_cnt = 8'd200;
      run_cmd(2'd0, 0, 0);
      chk("R7 large hold clamped", strobe_at, 11);
      sda_hold_cnt = 8'd9;
      run_cmd(2'd0, 0, 0);
      chk("R7 hold at clamp edge", strobe_at, 11);
      sda_hold_cnt = 8'd8;
      run_cmd(2'd0, 0, 0);
      chk("R6 hold just below clamp", strobe_at, 10);
   endtask

   task automatic t_stretch();
      speed_mode = 2'd1; std_hi = 8'd10; std_lo = 8'd12; sda_hold_cnt = 8'd3;
      run_cmd(2'd0, 5, 0);
      chk("R8 stretched high length", hi_n, 23);
      chk("R8 stretch flag cycles", str_n, 5);
      chk("R9 sample after stretch", samp_at, 14);
      chk("R3 low unaffected by stretch", low_n, 13);
   endtask

   task automatic t_start_then_bit();
      speed_mode = 2'd1; std_hi = 8'd10; std_lo = 8'd12; sda_hold_cnt = 8'd3;
      run_cmd(2'd1, 0, 0);
      chk("R10 start low length", low_n, 13);
      chk("R10 start high total", hi_n, 36);
      chk("R10 start SDA fall point", hl_hi_rise, 18);
      chk("R9 no sample on start", nsamp, 0);
      chk("R10 SDA held low after start", int'(sda_cond_low), 1);
      run_cmd(2'd0, 0, 0);
      chk("R10 held low until strobe ends", hl_low_fall, 6);
      chk("R10 released after bit", int'(sda_cond_low), 0);
   endtask

   task automatic t_stop();
      speed_mode = 2'd1; std_hi = 8'd10; std_lo = 8'd12; sda_hold_cnt = 8'd3;
      run_cmd(2'd2, 0, 0);
      chk("R11 stop low length", low_n, 13);
      chk("R11 SDA pulled low after strobe", hl_low_first, 6);
      chk("R11 stop high total", hi_n, 36);
      chk("R11 SDA release point", hl_hi_fall, 18);
      chk("R9 no sample on stop", nsamp, 0);
      chk("R11 released after stop", int'(sda_cond_low), 0);
   endtask

   task automatic t_latch();
      int extra_low = 0;
      speed_mode = 2'd1; std_hi = 8'd10; std_lo = 8'd12; sda_hold_cnt = 8'd3;
      run_cmd(2'd0, 0, 1);
      chk("R12 low length kept", low_n, 13);
      chk("R12 high length kept", hi_n, 18);
      chk("R12 hold kept", strobe_at, 5);
      chk("R12 busy request dropped, no cond", hl_low_first, -1);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk); #1;
         if (scl_low) extra_low++;
      end
      chk("R12 no second command", extra_low, 0);
      chk("R1 ready when idle", int'(cmd_ready), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_standard();
      t_fast();
      t_high_speed();
      t_speed_zero();
      t_minimums();
      t_hold_clamp();
      t_stretch();
      t_start_then_bit();
      t_stop();
      t_latch();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule